// File: doc/BRIEF.md
# Radio Power Mode Sequencer

This block steps a radio core through its power modes: a quiet reset mode, two sleep modes with different depths, an idle mode with the host port live, a warm-up mode, and the two active modes, receive and transmit. It drives the oscillator, host-port, receiver and transmitter enables, a busy flag and a 3-bit mode code. A host asks for a sleep mode with a one-cycle command while the core is idle. It wakes the core with an active-low wake pin or, from the lighter sleep, with a timer match. Receive or transmit starts on a rising edge of a run pin, and the core drops back to idle whenever that pin goes low.

The wake pin and the run pin are asynchronous, so each one goes through a synchronizer chain before any edge or level is decoded. The oscillator restart after either sleep mode and the 144 µs radio warm-up (2304 cycles of a 16 MHz reference) are counted on one shared down-counter. The receiver and transmitter enables rise only when that count has finished.

Top module: `radio_pwr_seq`

## Requirements
- R1: While rst_n is low the mode code is 0 (Off) and every output, including pad_oe, is low. At the first clock edge after rst_n rises the mode code becomes 4 (Idle).
- R2: In Idle, a cycle with cmd_valid high and cmd_op = 2'b01 enters Hibernate (code 1) at the next edge, and cmd_op = 2'b10 enters Doze (code 2). cmd_op values 2'b00 and 2'b11 leave the mode unchanged.
- R3: A command presented in any mode other than Idle leaves the mode unchanged.
- R4: A low level on attn_n during Hibernate or Doze moves the block to Wake (code 3) at the third clock edge after the pin falls: two synchronizer edges plus one state edge.
- R5: A high timer_match during Doze moves the block to Wake at the next edge. timer_match has no effect in Hibernate.
- R6: Wake lasts HIB_WAKE_CYCLES cycles (default 64) when entered from Hibernate and DOZE_WAKE_CYCLES cycles (default 16) when entered from Doze. After that the mode is Idle.
- R7: A rising edge of rxtx_en in Idle enters Warm-up (code 5) at the third clock edge after the pin rises. mode_sel sampled at that edge selects the target: 0 for Receive (code 6), 1 for Transmit (code 7). Later changes to mode_sel have no effect on the sequence already started.
- R8: Warm-up lasts WARM_CYCLES cycles (default 2304) and then enters the selected active mode. rx_en is high only in Receive and tx_en only in Transmit.
- R9: rxtx_en low during Warm-up, Receive or Transmit returns the block to Idle at the third clock edge after the pin falls.
- R10: osc_en is high in every mode except Off and Hibernate. spi_en is high in Idle, Warm-up, Receive and Transmit. out_of_idle is high in Warm-up, Receive and Transmit. busy_gpio equals out_of_idle AND alt_en. pad_oe is high in every mode except Off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset; holds the Off mode |
| attn_n | input | 1 | Asynchronous active-low wake request |
| rxtx_en | input | 1 | Asynchronous run pin; rising edge starts, low cancels |
| mode_sel | input | 1 | Sequence direction: 0 receive, 1 transmit |
| cmd_valid | input | 1 | One-cycle strobe qualifying cmd_op |
| cmd_op | input | 2 | 01 Hibernate, 10 Doze, others none |
| timer_match | input | 1 | Wake-timer compare match |
| alt_en | input | 1 | Routes out_of_idle onto busy_gpio |
| pad_oe | output | 1 | Pad drive enable, low in Off (pads tri-stated) |
| osc_en | output | 1 | Reference oscillator enable |
| spi_en | output | 1 | Host serial port enable |
| rx_en | output | 1 | Receiver enable |
| tx_en | output | 1 | Transmitter enable |
| out_of_idle | output | 1 | A radio sequence is in progress |
| busy_gpio | output | 1 | Alternate-function copy of out_of_idle |
| mode | output | 3 | Current mode code |

## Verification
Every cycle, the assertions check the local transition rules. The wake pin and the timer each force Wake out of the sleep modes. A low run pin forces Idle out of any active mode. Sleep modes are entered only from Idle, active modes only from Warm-up, and the two radio enables never overlap. The exact cycle counts only show up in the bench's scenarios, which count Wake and Warm-up lengths, the synchronizer latency of the pins and the direction latched at the start. The same holds for commands being ignored outside Idle while the block sits in sleep, warm-up or an active mode.

// File: rtl/rmc_pkg.sv
package rmc_pkg;
   typedef enum logic [2:0] {
      M_OFF  = 3'd0,
      M_HIB  = 3'd1,
      M_DOZE = 3'd2,
      M_WAKE = 3'd3,
      M_IDLE = 3'd4,
      M_WARM = 3'd5,
      M_RX   = 3'd6,
      M_TX   = 3'd7
   } rmc_mode_e;

   typedef enum logic [1:0] {
      OP_NONE = 2'b00,
      OP_HIB  = 2'b01,
      OP_DOZE = 2'b10,
      OP_RSVD = 2'b11
   } rmc_op_e;
endpackage

// File: rtl/rmc_sync.sv
module rmc_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   if (STAGES < 2) begin : g_bad_stages
      $error("rmc_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RST_VAL;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RST_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rmc_timer.sv
module rmc_timer #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);
   logic [W-1:0] cnt;

   if (W < 1) begin : g_bad_width
      $error("rmc_timer: W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);
endmodule

// File: rtl/rmc_decode.sv
module rmc_decode
   import rmc_pkg::*;
(
   input  rmc_mode_e st,
   input  logic      alt_en,
   output logic      pad_oe,
   output logic      osc_en,
   output logic      spi_en,
   output logic      rx_en,
   output logic      tx_en,
   output logic      out_of_idle,
   output logic      busy_gpio
);
   always_comb begin
      pad_oe      = 1'b1;
      osc_en      = 1'b1;
      spi_en      = 1'b0;
      rx_en       = 1'b0;
      tx_en       = 1'b0;
      out_of_idle = 1'b0;
      unique case (st)
         M_OFF:  begin pad_oe = 1'b0; osc_en = 1'b0; end
         M_HIB:  osc_en = 1'b0;
         M_DOZE, M_WAKE: ;
         M_IDLE: spi_en = 1'b1;
         M_WARM: begin spi_en = 1'b1; out_of_idle = 1'b1; end
         M_RX:   begin spi_en = 1'b1; out_of_idle = 1'b1; rx_en = 1'b1; end
         M_TX:   begin spi_en = 1'b1; out_of_idle = 1'b1; tx_en = 1'b1; end
         default: ;
      endcase
      busy_gpio = out_of_idle & alt_en;
   end
endmodule

// File: rtl/radio_pwr_seq.sv
module radio_pwr_seq
   import rmc_pkg::*;
#(
   parameter int WARM_CYCLES      = 2304,
   parameter int HIB_WAKE_CYCLES  = 64,
   parameter int DOZE_WAKE_CYCLES = 16,
   parameter int SYNC_STAGES      = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       attn_n,
   input  logic       rxtx_en,
   input  logic       mode_sel,
   input  logic       cmd_valid,
   input  logic [1:0] cmd_op,
   input  logic       timer_match,
   input  logic       alt_en,
   output logic       pad_oe,
   output logic       osc_en,
   output logic       spi_en,
   output logic       rx_en,
   output logic       tx_en,
   output logic       out_of_idle,
   output logic       busy_gpio,
   output logic [2:0] mode
);
   localparam int MAX_A = (WARM_CYCLES > HIB_WAKE_CYCLES) ? WARM_CYCLES : HIB_WAKE_CYCLES;
   localparam int MAX_CYC = (MAX_A > DOZE_WAKE_CYCLES) ? MAX_A : DOZE_WAKE_CYCLES;
   localparam int CW = $clog2(MAX_CYC + 1);

   if (WARM_CYCLES < 1 || HIB_WAKE_CYCLES < 1 || DOZE_WAKE_CYCLES < 1) begin : g_bad_cycles
      $error("radio_pwr_seq: every cycle count must be at least 1");
   end

   rmc_mode_e       st, nxt;
   logic            attn_s, rxtx_s, rxtx_prev, rise;
   logic            dir_q;
   logic            t_load, t_done;
   logic [CW-1:0]   t_val;

   rmc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_attn (
      .clk(clk), .rst_n(rst_n), .d(attn_n), .q(attn_s));

   rmc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_run (
      .clk(clk), .rst_n(rst_n), .d(rxtx_en), .q(rxtx_s));

   rmc_timer #(.W(CW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .done(t_done));

   assign rise = rxtx_s & ~rxtx_prev;

   always_comb begin
      nxt    = st;
      t_load = 1'b0;
      t_val  = '0;
      unique case (st)
         M_OFF:  nxt = M_IDLE;
         M_IDLE: begin
            if (rise) begin
               nxt    = M_WARM;
               t_load = 1'b1;
               t_val  = CW'(WARM_CYCLES - 1);
            end else if (cmd_valid && cmd_op == OP_HIB) begin
               nxt = M_HIB;
            end else if (cmd_valid && cmd_op == OP_DOZE) begin
               nxt = M_DOZE;
            end
         end
         M_HIB: begin
            if (!attn_s) begin
               nxt    = M_WAKE;
               t_load = 1'b1;
               t_val  = CW'(HIB_WAKE_CYCLES - 1);
            end
         end
         M_DOZE: begin
            if (!attn_s || timer_match) begin
               nxt    = M_WAKE;
               t_load = 1'b1;
               t_val  = CW'(DOZE_WAKE_CYCLES - 1);
            end
         end
         M_WAKE: if (t_done) nxt = M_IDLE;
         M_WARM: begin
            if (!rxtx_s)     nxt = M_IDLE;
            else if (t_done) nxt = dir_q ? M_TX : M_RX;
         end
         M_RX, M_TX: if (!rxtx_s) nxt = M_IDLE;
         default: nxt = M_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= M_OFF;
         rxtx_prev <= 1'b0;
         dir_q     <= 1'b0;
      end else begin
         st        <= nxt;
         rxtx_prev <= rxtx_s;
         if (st == M_IDLE && rise) dir_q <= mode_sel;
      end
   end

   rmc_decode u_decode (
      .st(st), .alt_en(alt_en), .pad_oe(pad_oe), .osc_en(osc_en), .spi_en(spi_en),
      .rx_en(rx_en), .tx_en(tx_en), .out_of_idle(out_of_idle), .busy_gpio(busy_gpio));

   assign mode = st;

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_OFF_QUIET: assert (!pad_oe && !osc_en && !spi_en && !rx_en && !tx_en && mode == 3'd0); // R1
      end
   end

   AST_SLEEP_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == M_HIB || st == M_DOZE) && $past(st) != st) |-> $past(st) == M_IDLE); // R2

   AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (st inside {M_WARM, M_RX, M_TX} && cmd_valid) |=> !(st inside {M_HIB, M_DOZE})); // R3

   AST_ATTN_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (st inside {M_HIB, M_DOZE} && !attn_s) |=> st == M_WAKE); // R4

   AST_TIMER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == M_DOZE && timer_match) |=> st == M_WAKE); // R5

   AST_ACTIVE_AFTER_WARM: assert property (@(posedge clk) disable iff (!rst_n)
      (st inside {M_RX, M_TX} && $past(st) != st) |-> $past(st) == M_WARM); // R8

   AST_RUN_LOW_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
      (st inside {M_WARM, M_RX, M_TX} && !rxtx_s) |=> st == M_IDLE); // R9

   AST_RADIO_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en || tx_en) |-> (osc_en && spi_en && !(rx_en && tx_en))); // R10
endmodule

// File: tb/radio_pwr_seq_test.sv
module radio_pwr_seq_test;
   localparam int CLK_PERIOD = 10;
   localparam int WARM = 2304;
   localparam int HIBW = 64;
   localparam int DOZW = 16;

   logic clk = 1'b0;
   logic rst_n, attn_n, rxtx_en, mode_sel, cmd_valid, timer_match, alt_en;
   logic [1:0] cmd_op;
   logic pad_oe, osc_en, spi_en, rx_en, tx_en, out_of_idle, busy_gpio;
   logic [2:0] mode;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   radio_pwr_seq uut (
      .clk(clk), .rst_n(rst_n), .attn_n(attn_n), .rxtx_en(rxtx_en), .mode_sel(mode_sel),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .timer_match(timer_match), .alt_en(alt_en),
      .pad_oe(pad_oe), .osc_en(osc_en), .spi_en(spi_en), .rx_en(rx_en), .tx_en(tx_en),
      .out_of_idle(out_of_idle), .busy_gpio(busy_gpio), .mode(mode));

   // Expected {pad_oe, osc_en, spi_en, rx_en, tx_en, out_of_idle, busy_gpio} per R1 and R10
   function automatic logic [6:0] exp_outs(input logic [2:0] m, input logic alt);
      logic pad, osc, spi, rx, tx, ooi;
      pad = (m != 3'd0);
      osc = (m != 3'd0) && (m != 3'd1);
      spi = (m >= 3'd4);
      rx  = (m == 3'd6);
      tx  = (m == 3'd7);
      ooi = (m >= 3'd5);
      return {pad, osc, spi, rx, tx, ooi, ooi & alt};
   endfunction

   task automatic chk_eq(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   // R10 monitor: outputs decoded from the observed mode code
   always @(negedge clk) begin
      if (!finished)
         chk_eq("R10 output decode", int'({pad_oe, osc_en, spi_en, rx_en, tx_en, out_of_idle, busy_gpio}),
                int'(exp_outs(mode, alt_en)));
   end

   task automatic do_sleep(input bit doze, input bit by_timer);
      int n;
      int sm;
      sm = doze ? 2 : 1;
      cmd_valid = 1'b1; cmd_op = doze ? 2'b10 : 2'b01;
      step(1);
      cmd_valid = 1'b0; cmd_op = 2'b00;
      chk_eq("R2 sleep entry", int'(mode), sm);
      cmd_valid = 1'b1; cmd_op = doze ? 2'b01 : 2'b10;
      step(1);
      cmd_valid = 1'b0; cmd_op = 2'b00;
      chk_eq("R3 command in sleep ignored", int'(mode), sm);
      if (!doze) begin
         timer_match = 1'b1; step(1); timer_match = 1'b0;
         chk_eq("R5 timer ignored in hibernate", int'(mode), 1);
      end
      if (by_timer) begin
         timer_match = 1'b1; step(1); timer_match = 1'b0;
         chk_eq("R5 timer wake", int'(mode), 3);
      end else begin
         attn_n = 1'b0;
         step(2);
         chk_eq("R4 wake latency early", int'(mode), sm);
         step(1);
         chk_eq("R4 wake latency", int'(mode), 3);
      end
      n = 1;
      step(1);
      while (mode == 3'd3 && n < 100000) begin n++; step(1); end
      chk_eq("R6 wake length", n, doze ? DOZW : HIBW);
      chk_eq("R6 back to idle", int'(mode), 4);
      attn_n = 1'b1;
      step(3);
   endtask

   task automatic do_active(input bit tx, input int cancel_at);
      int n;
      mode_sel = tx; rxtx_en = 1'b1;
      step(2);
      chk_eq("R7 start latency early", int'(mode), 4);
      step(1);
      chk_eq("R7 warm-up entry", int'(mode), 5);
      mode_sel = ~tx;
      cmd_valid = 1'b1; cmd_op = 2'b01;
      step(1);
      cmd_valid = 1'b0; cmd_op = 2'b00;
      chk_eq("R3 command in warm-up ignored", int'(mode), 5);
      if (cancel_at > 0) begin
         step(cancel_at);
         rxtx_en = 1'b0;
         step(2);
         chk_eq("R9 cancel latency early", int'(mode), 5);
         step(1);
         chk_eq("R9 cancel to idle", int'(mode), 4);
      end else begin
         n = 2;
         step(1);
         while (mode == 3'd5 && n < 100000) begin n++; step(1); end
         chk_eq("R8 warm-up length", n, WARM);
         chk_eq("R7 latched direction", int'(mode), tx ? 7 : 6);
         step(5);
         cmd_valid = 1'b1; cmd_op = 2'b10;
         step(1);
         cmd_valid = 1'b0; cmd_op = 2'b00;
         chk_eq("R3 command in active ignored", int'(mode), tx ? 7 : 6);
         rxtx_en = 1'b0;
         step(2);
         chk_eq("R9 active hold", int'(mode), tx ? 7 : 6);
         step(1);
         chk_eq("R9 active to idle", int'(mode), 4);
      end
      step(2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 1, 0);
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int sel;
      void'($urandom(32'd1207));
      rst_n = 1'b0; attn_n = 1'b1; rxtx_en = 1'b0; mode_sel = 1'b0;
      cmd_valid = 1'b0; cmd_op = 2'b00; timer_match = 1'b0; alt_en = 1'b1;
      step(4);
      chk_eq("R1 off during reset", int'(mode), 0);
      chk_eq("R1 pads quiet", int'(pad_oe), 0);
      rst_n = 1'b1;
      step(1);
      chk_eq("R1 idle after release", int'(mode), 4);

      cmd_valid = 1'b1; cmd_op = 2'b11;
      step(1);
      cmd_valid = 1'b0; cmd_op = 2'b00;
      chk_eq("R2 reserved op ignored", int'(mode), 4);
      cmd_op = 2'b01;
      step(1);
      cmd_op = 2'b00;
      chk_eq("R2 op without valid ignored", int'(mode), 4);

      do_sleep(1'b0, 1'b0);
      do_sleep(1'b1, 1'b0);
      do_sleep(1'b1, 1'b1);
      do_active(1'b0, 0);
      alt_en = 1'b0;
      do_active(1'b1, 0);
      do_active(1'b0, 1);

      for (int i = 0; i < 14; i++) begin
         alt_en = 1'($urandom_range(0, 1));
         sel = int'($urandom_range(0, 3));
         case (sel)
            0: do_sleep(1'b0, 1'b0);
            1: do_sleep(1'b1, 1'b0);
            2: do_sleep(1'b1, 1'b1);
            default: do_active(1'($urandom_range(0, 1)),
                               ($urandom_range(0, 1) != 0) ? int'($urandom_range(1, 200)) : 0);
         endcase
      end

      rst_n = 1'b0;
      step(1);
      chk_eq("R1 reset from idle", int'(mode), 0);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule